// File: doc/BRIEF.md
# Multi-Tag Address-Space-Checked Translation Match Unit

This block searches a small table of translation entries for the entry that covers an effective address. An entry takes part only if it is valid, if its process tag fits the current process identifiers, and if its address-space bit equals the relocation bit for the kind of access. The first entry in ascending index order that meets all three conditions decides the result. The unit then picks that entry's user or supervisor permission nibble, checks it against the access, and forms the real address from the entry's page number and the page offset. Table contents are loaded one entry at a time through a write port.

Three tag registers are inputs. Tag 0 is always consulted. A mode input enables the two secondary tags. Without secondary tags, the real address widens from 32 to 36 bits, using the low nibble of the stored page number. Page sizes come from a 3-bit size code per entry.

A lookup is requested by a one-cycle strobe. A two-state controller, `ST_IDLE` and `ST_REPORT`, presents the registered result for one cycle after each strobe. Its transitions are:
- `ST_IDLE`→`ST_REPORT` when a strobe arrives.
- `ST_REPORT`→`ST_REPORT` when back-to-back strobes arrive.
- `ST_REPORT`→`ST_IDLE` otherwise.

Top module: `tlb_pid_match`

## Requirements
- R1: `res_valid` is high in exactly the cycle after each cycle with `lk_valid` high. The result outputs are updated from the lookup inputs sampled at that strobe edge.
- R2: A write with `wr_en` high replaces entry `wr_idx` at the clock edge. A lookup strobed in the same cycle still sees the old contents.
- R3: An entry matches an effective address only if its valid bit is set and (ea AND mask) equals its stored page number. The page size is 1 KiB << (2 × size code), size code 0..7, and mask is the inverse of (page size − 1).
- R4: Tag fit works as follows:
  - An entry tag of 0 fits any process.
  - Otherwise the tag must equal `pid0`.
  - When `sec_pids` is 1, the tag may instead equal `pid1` if `pid1` is nonzero, or `pid2` if `pid2` is nonzero.
  - When `sec_pids` is 0, `pid1` and `pid2` are ignored.
- R5: The required address-space bit is `as_instr` for fetches and `as_data` for loads and stores. An entry whose stored bit differs counts as a miss.
- R6: The lowest-index entry that is not a miss decides the result, even when a higher entry would grant the access.
- R7: On a hit, `res_ra[31:0]` = (rpn AND mask) OR (ea AND NOT mask).
- R8: On a hit, `res_ra[35:32]` holds rpn[3:0] when `sec_pids` is 0, and holds zero when `sec_pids` is 1.
- R9: Rights come from the permission field as follows:
  - The field is prot[3:0] for a user access (`lk_user`=1) and prot[7:4] for a supervisor access.
  - In the selected nibble, bit 0 is read, bit 1 is write and bit 2 is execute. Bit 3 is ignored.
  - `res_rights` shows nibble bits 2:0 whenever an entry was selected, and is zero on a miss.
- R10: Access codes are 0 load, 1 store, 2 fetch, and 3 acts as a load. Loads need read, stores need write and fetches need execute. Result codes are:
  - 0: hit.
  - 1: miss.
  - 2: protection fault on a load or store.
  - 3: execute fault on a fetch.
  
  `res_ra` is zero unless the result is a hit.
- R11: After reset all entries are invalid, `res_valid` is 0, `res_code` is 1 (miss) and `res_ra` and `res_rights` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Entry write strobe |
| wr_idx | input | clog2(NUM_ENTRIES) | Index of the entry to write |
| wr_vld | input | 1 | Valid bit of the written entry |
| wr_epn | input | 32 | Effective page number (page-aligned address) |
| wr_rpn | input | 32 | Real page number; bits 3:0 also feed the address extension |
| wr_tag | input | 8 | Process tag, 0 = global |
| wr_size | input | 3 | Page size code |
| wr_as | input | 1 | Address-space bit of the entry |
| wr_prot | input | 8 | Permissions: [7:4] supervisor, [3:0] user |
| lk_valid | input | 1 | Lookup strobe |
| lk_ea | input | 32 | Effective address |
| lk_access | input | 2 | Access type code |
| lk_user | input | 1 | 1 = user privilege |
| as_instr | input | 1 | Instruction relocation bit |
| as_data | input | 1 | Data relocation bit |
| pid0 | input | 8 | Primary process tag |
| pid1 | input | 8 | First secondary tag |
| pid2 | input | 8 | Second secondary tag |
| sec_pids | input | 1 | 1 = secondary tags present |
| res_valid | output | 1 | Result present |
| res_ra | output | 36 | Real address |
| res_rights | output | 3 | Granted rights (X, W, R) |
| res_code | output | 2 | Result code |

## Verification
The hardest situation to reach is one where an early entry matches on tag and address but its permissions refuse the access, while a later entry would grant it. The stimulus writes two overlapping entries and checks that the fault from the earlier entry wins. It then flips the earlier entry's address-space bit and checks that the later entry takes over.

Beyond that case, the bench sweeps a handful of conditions across eight entries of mixed page size, tag, address-space bit and permission byte:
- every access type and privilege level;
- both relocation bits;
- both tag modes;
- two sets of tag register values, one with a zero secondary tag.

It also probes addresses just inside and just past each page.

// File: rtl/tlbm_pkg.sv
package tlbm_pkg;

    localparam int EA_W      = 32;
    localparam int RA_W      = 36;
    localparam int PID_W     = 8;
    localparam int SZ_W      = 3;
    localparam int PROT_W    = 8;
    localparam int MIN_PG_LG = 10;
    localparam int EXT_W     = RA_W - EA_W;

    typedef struct packed {
        logic              vld;
        logic [EA_W-1:0]   epn;
        logic [EA_W-1:0]   rpn;
        logic [PID_W-1:0]  tag;
        logic [SZ_W-1:0]   sz;
        logic              asb;
        logic [PROT_W-1:0] prot;
    } tlb_ent_t;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_e;

    typedef enum logic [1:0] {
        RES_HIT   = 2'd0,
        RES_MISS  = 2'd1,
        RES_DPROT = 2'd2,
        RES_XPROT = 2'd3
    } res_e;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_REPORT = 1'b1
    } fsm_e;

    function automatic logic [EA_W-1:0] page_mask(input logic [SZ_W-1:0] sz);
        logic [EA_W-1:0] one;
        one = {{(EA_W-1){1'b0}}, 1'b1};
        return ~((one << (MIN_PG_LG + 2 * int'(sz))) - one);
    endfunction

endpackage

// File: rtl/tlb_entry_store.sv
module tlb_entry_store
    import tlbm_pkg::*;
#(
    parameter int NUM_ENTRIES = 64,
    localparam int IDX_W = $clog2(NUM_ENTRIES)
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         wr_en,
    input  logic [IDX_W-1:0]             wr_idx,
    input  tlb_ent_t                     wr_ent,
    output tlb_ent_t [NUM_ENTRIES-1:0]   ents
);

    for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_ent
        always_ff @(posedge clk) begin
            if (rst) begin
                ents[g].vld <= 1'b0;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                ents[g] <= wr_ent;
            end
        end
    end

    // R2: a written entry holds the written value on the next cycle
    p_write_lands_r2: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (ents[$past(wr_idx)] == $past(wr_ent)));

endmodule

// File: rtl/tlb_entry_cmp.sv
module tlb_entry_cmp
    import tlbm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              vld,
    input  logic [EA_W-1:0]   epn,
    input  logic [PID_W-1:0]  tag,
    input  logic [SZ_W-1:0]   sz,
    input  logic              asb,
    input  logic [EA_W-1:0]   ea,
    input  logic [PID_W-1:0]  pid0,
    input  logic [PID_W-1:0]  pid1,
    input  logic [PID_W-1:0]  pid2,
    input  logic              sec_pids,
    input  logic              as_req,
    output logic              match
);

    logic tag_primary;
    logic tag_sec1;
    logic tag_sec2;
    logic tag_ok;
    logic ea_ok;

    always_comb begin
        tag_primary = (tag == '0) || (tag == pid0);
        tag_sec1    = sec_pids && (pid1 != '0) && (tag == pid1);
        tag_sec2    = sec_pids && (pid2 != '0) && (tag == pid2);
        tag_ok      = tag_primary || tag_sec1 || tag_sec2;
        ea_ok       = ((ea & page_mask(sz)) == epn);
        match       = vld && tag_ok && ea_ok && (asb == as_req);
    end

    // R3: an invalid entry never matches
    p_invalid_quiet_r3: assert property (@(posedge clk) disable iff (rst)
        !vld |-> !match);

    // R5: a matching entry agrees with the requested address space
    p_space_agrees_r5: assert property (@(posedge clk) disable iff (rst)
        match |-> (asb == as_req));

endmodule

// File: rtl/tlb_first_pick.sv
module tlb_first_pick #(
    parameter int WIDTH = 64
) (
    input  logic [WIDTH-1:0] req,
    output logic [WIDTH-1:0] gnt,
    output logic             any
);

    always_comb begin
        gnt = req & (~req + WIDTH'(1));
        any = |req;
    end

endmodule

// File: rtl/tlb_pid_match.sv
module tlb_pid_match
    import tlbm_pkg::*;
#(
    parameter int NUM_ENTRIES = 64
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           wr_en,
    input  logic [$clog2(NUM_ENTRIES)-1:0] wr_idx,
    input  logic                           wr_vld,
    input  logic [31:0]                    wr_epn,
    input  logic [31:0]                    wr_rpn,
    input  logic [7:0]                     wr_tag,
    input  logic [2:0]                     wr_size,
    input  logic                           wr_as,
    input  logic [7:0]                     wr_prot,
    input  logic                           lk_valid,
    input  logic [31:0]                    lk_ea,
    input  logic [1:0]                     lk_access,
    input  logic                           lk_user,
    input  logic                           as_instr,
    input  logic                           as_data,
    input  logic [7:0]                     pid0,
    input  logic [7:0]                     pid1,
    input  logic [7:0]                     pid2,
    input  logic                           sec_pids,
    output logic                           res_valid,
    output logic [35:0]                    res_ra,
    output logic [2:0]                     res_rights,
    output logic [1:0]                     res_code
);

    localparam int IDX_W = $clog2(NUM_ENTRIES);

    tlb_ent_t                   wr_ent;
    tlb_ent_t [NUM_ENTRIES-1:0] ents;
    logic [NUM_ENTRIES-1:0]     hits;
    logic [NUM_ENTRIES-1:0]     gnt;
    logic                       any_hit;
    logic                       as_req;
    acc_e                       acc;
    tlb_ent_t                   sel;
    logic [EA_W-1:0]            mask;
    logic [EA_W-1:0]            ra_low;
    logic [EXT_W-1:0]           ra_ext;
    logic [3:0]                 nib;
    logic [1:0]                 need;
    logic                       allowed;
    res_e                       code_d;
    fsm_e                       state_q;
    fsm_e                       state_d;
    logic [RA_W-1:0]            ra_q;
    logic [2:0]                 rights_q;
    res_e                       code_q;

    always_comb begin
        wr_ent.vld  = wr_vld;
        wr_ent.epn  = wr_epn;
        wr_ent.rpn  = wr_rpn;
        wr_ent.tag  = wr_tag;
        wr_ent.sz   = wr_size;
        wr_ent.asb  = wr_as;
        wr_ent.prot = wr_prot;
        acc         = acc_e'(lk_access);
        as_req      = (acc == ACC_FETCH) ? as_instr : as_data;
    end

    tlb_entry_store #(.NUM_ENTRIES(NUM_ENTRIES)) u_store (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en),
        .wr_idx (wr_idx[IDX_W-1:0]),
        .wr_ent (wr_ent),
        .ents   (ents)
    );

    for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_cmp
        tlb_entry_cmp u_cmp (
            .clk      (clk),
            .rst      (rst),
            .vld      (ents[g].vld),
            .epn      (ents[g].epn),
            .tag      (ents[g].tag),
            .sz       (ents[g].sz),
            .asb      (ents[g].asb),
            .ea       (lk_ea),
            .pid0     (pid0),
            .pid1     (pid1),
            .pid2     (pid2),
            .sec_pids (sec_pids),
            .as_req   (as_req),
            .match    (hits[g])
        );
    end

    tlb_first_pick #(.WIDTH(NUM_ENTRIES)) u_pick (
        .req (hits),
        .gnt (gnt),
        .any (any_hit)
    );

    // Selected entry, formed from the one-hot grant
    always_comb begin
        sel = '0;
        for (int i = 0; i < NUM_ENTRIES; i++) begin
            if (gnt[i]) begin
                sel = tlb_ent_t'(sel | ents[i]);
            end
        end
    end

    // Address formation and permission decision
    always_comb begin
        mask    = page_mask(sel.sz);
        ra_low  = (sel.rpn & mask) | (lk_ea & ~mask);
        ra_ext  = sec_pids ? '0 : sel.rpn[EXT_W-1:0];
        nib     = lk_user ? sel.prot[3:0] : sel.prot[7:4];
        unique case (acc)
            ACC_STORE: need = 2'd1;
            ACC_FETCH: need = 2'd2;
            default:   need = 2'd0;
        endcase
        allowed = nib[need];
        if (!any_hit) begin
            code_d = RES_MISS;
        end else if (allowed) begin
            code_d = RES_HIT;
        end else if (acc == ACC_FETCH) begin
            code_d = RES_XPROT;
        end else begin
            code_d = RES_DPROT;
        end
    end

    // Controller: state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        unique case (state_q)
            ST_IDLE:   state_d = lk_valid ? ST_REPORT : ST_IDLE;
            ST_REPORT: state_d = lk_valid ? ST_REPORT : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Result registers, captured at each strobe
    always_ff @(posedge clk) begin
        if (rst) begin
            ra_q     <= '0;
            rights_q <= '0;
            code_q   <= RES_MISS;
        end else if (lk_valid) begin
            ra_q     <= (code_d == RES_HIT) ? {ra_ext, ra_low} : '0;
            rights_q <= any_hit ? nib[2:0] : 3'b000;
            code_q   <= code_d;
        end
    end

    // Controller: outputs
    always_comb begin
        res_valid  = (state_q == ST_REPORT);
        res_ra     = ra_q;
        res_rights = rights_q;
        res_code   = code_q;
    end

    // R1: one result cycle follows each strobe
    p_one_result_r1: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (res_valid == $past(lk_valid)));

    // R8: no upper address bits when secondary tags are present
    p_no_ext_sec_r8: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(lk_valid) && $past(sec_pids)) |-> (res_ra[35:32] == 4'h0));

    // R10: execute fault only for fetches
    p_xfault_fetch_r10: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(lk_valid) && (res_code == RES_XPROT)) |-> ($past(lk_access) == ACC_FETCH));

    // R10: data protection fault never for fetches
    p_dfault_data_r10: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(lk_valid) && (res_code == RES_DPROT)) |-> ($past(lk_access) != ACC_FETCH));

    // R9: a granted store carries the write right
    p_store_write_r9: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(lk_valid) && $past(lk_access) == ACC_STORE && res_code == RES_HIT) |-> res_rights[1]);

endmodule

// File: tb/tlb_pid_match_tb.sv
module tlb_pid_match_tb;

    localparam int N = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_idx = '0;
    logic        wr_vld = 1'b0;
    logic [31:0] wr_epn = '0;
    logic [31:0] wr_rpn = '0;
    logic [7:0]  wr_tag = '0;
    logic [2:0]  wr_size = '0;
    logic        wr_as = 1'b0;
    logic [7:0]  wr_prot = '0;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_ea = '0;
    logic [1:0]  lk_access = '0;
    logic        lk_user = 1'b0;
    logic        as_instr = 1'b0;
    logic        as_data = 1'b0;
    logic [7:0]  pid0 = '0;
    logic [7:0]  pid1 = '0;
    logic [7:0]  pid2 = '0;
    logic        sec_pids = 1'b0;
    logic        res_valid;
    logic [35:0] res_ra;
    logic [2:0]  res_rights;
    logic [1:0]  res_code;

    int checks = 0;
    int failures = 0;

    logic        m_vld  [N];
    logic [31:0] m_epn  [N];
    logic [31:0] m_rpn  [N];
    logic [7:0]  m_tag  [N];
    logic [2:0]  m_sz   [N];
    logic        m_as   [N];
    logic [7:0]  m_prot [N];

    always #5 clk = ~clk;

    tlb_pid_match #(.NUM_ENTRIES(N)) u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_vld(wr_vld),
        .wr_epn(wr_epn), .wr_rpn(wr_rpn), .wr_tag(wr_tag), .wr_size(wr_size),
        .wr_as(wr_as), .wr_prot(wr_prot), .lk_valid(lk_valid), .lk_ea(lk_ea),
        .lk_access(lk_access), .lk_user(lk_user), .as_instr(as_instr),
        .as_data(as_data), .pid0(pid0), .pid1(pid1), .pid2(pid2),
        .sec_pids(sec_pids), .res_valid(res_valid), .res_ra(res_ra),
        .res_rights(res_rights), .res_code(res_code)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] pg_size(input logic [2:0] sz);
        return 32'd1 << (10 + 2 * int'(sz));
    endfunction

    task automatic write_ent(input int idx, input logic vld, input logic [31:0] epn,
                             input logic [31:0] rpn, input logic [7:0] tag,
                             input logic [2:0] sz, input logic asb, input logic [7:0] prot);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 3'(idx); wr_vld = vld; wr_epn = epn; wr_rpn = rpn;
        wr_tag = tag; wr_size = sz; wr_as = asb; wr_prot = prot;
        @(negedge clk);
        wr_en = 1'b0;
        m_vld[idx] = vld; m_epn[idx] = epn; m_rpn[idx] = rpn; m_tag[idx] = tag;
        m_sz[idx] = sz; m_as[idx] = asb; m_prot[idx] = prot;
    endtask

    // Expected result built from the requirements
    task automatic model(input logic [31:0] ea, input logic [1:0] acc, input logic usr,
                         output logic [35:0] e_ra, output logic [2:0] e_rt, output logic [1:0] e_code);
        logic       reqas;
        logic [3:0] nib;
        logic       ok;
        logic [31:0] msk;
        reqas = (acc == 2'd2) ? as_instr : as_data;
        e_ra = '0; e_rt = '0; e_code = 2'd1;
        for (int i = 0; i < N; i++) begin
            logic tfit;
            msk  = ~(pg_size(m_sz[i]) - 32'd1);
            tfit = (m_tag[i] == 8'd0) || (m_tag[i] == pid0) ||
                   (sec_pids && pid1 != 0 && m_tag[i] == pid1) ||
                   (sec_pids && pid2 != 0 && m_tag[i] == pid2);
            if (m_vld[i] && tfit && ((ea & msk) == m_epn[i]) && (m_as[i] == reqas)) begin
                nib  = usr ? m_prot[i][3:0] : m_prot[i][7:4];
                e_rt = nib[2:0];
                ok   = (acc == 2'd1) ? nib[1] : (acc == 2'd2) ? nib[2] : nib[0];
                if (ok) begin
                    e_code = 2'd0;
                    e_ra = {sec_pids ? 4'h0 : m_rpn[i][3:0], (m_rpn[i] & msk) | (ea & ~msk)};
                end else begin
                    e_code = (acc == 2'd2) ? 2'd3 : 2'd2;
                end
                break;
            end
        end
    endtask

    task automatic lookup(input logic [31:0] ea, input logic [1:0] acc, input logic usr, input string tag);
        logic [35:0] e_ra;
        logic [2:0]  e_rt;
        logic [1:0]  e_code;
        @(negedge clk);
        lk_ea = ea; lk_access = acc; lk_user = usr; lk_valid = 1'b1;
        model(ea, acc, usr, e_ra, e_rt, e_code);
        @(negedge clk);
        lk_valid = 1'b0;
        chk({"R1 valid ", tag}, 64'(res_valid), 64'd1);
        chk({"R10 code ", tag}, 64'(res_code), 64'(e_code));
        chk({"R7 R8 ra ", tag}, 64'(res_ra), 64'(e_ra));
        chk({"R9 rights ", tag}, 64'(res_rights), 64'(e_rt));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int i = 0; i < N; i++) begin
            m_vld[i] = 1'b0; m_epn[i] = '0; m_rpn[i] = '0; m_tag[i] = '0;
            m_sz[i] = '0; m_as[i] = 1'b0; m_prot[i] = '0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R11: reset state
        chk("R11 valid", 64'(res_valid), 64'd0);
        chk("R11 code", 64'(res_code), 64'd1);
        chk("R11 ra", 64'(res_ra), 64'd0);
        chk("R11 rights", 64'(res_rights), 64'd0);
        pid0 = 8'd0;
        lookup(32'h0000_0000, 2'd0, 1'b0, "R11 empty table");

        // Table fill: mixed sizes, tags, spaces, permissions; entry 6 invalid (R3)
        for (int i = 0; i < N; i++) begin
            logic [7:0] tg;
            tg = (i % 4 == 0) ? 8'd0 : (i % 4 == 1) ? 8'd5 : (i % 4 == 2) ? 8'd6 : 8'd7;
            write_ent(i, (i != 6), 32'h1000_0000 + 32'(i) * 32'h0010_0000,
                      32'hABC0_0000 + 32'(i) * 32'h0003_0000 + 32'(i + 3),
                      tg, 3'(i % 4), 1'((i >> 1) & 1), 8'((i * 8'h5B) ^ 8'hA6));
        end

        // Sweep: R3 R4 R5 R7 R8 R9 R10
        for (int ps = 0; ps < 2; ps++) begin
            pid0 = 8'd5; pid1 = (ps == 0) ? 8'd6 : 8'd0; pid2 = 8'd7;
            for (int sec = 0; sec < 2; sec++) begin
                sec_pids = 1'(sec);
                for (int i = 0; i < N; i++) begin
                    for (int o = 0; o < 2; o++) begin
                        logic [31:0] ea;
                        logic [31:0] psz;
                        psz = pg_size(3'(i % 4));
                        ea  = 32'h1000_0000 + 32'(i) * 32'h0010_0000 +
                              ((o == 0) ? (32'h0001_2345 & (psz - 1)) : psz);
                        for (int acc = 0; acc < 4; acc++)
                            for (int usr = 0; usr < 2; usr++)
                                for (int ai = 0; ai < 2; ai++)
                                    for (int ad = 0; ad < 2; ad++) begin
                                        as_instr = 1'(ai); as_data = 1'(ad);
                                        lookup(ea, 2'(acc), 1'(usr), "R3 R4 R5 sweep");
                                    end
                    end
                end
            end
        end

        // R1: result lasts exactly one cycle
        @(negedge clk);
        chk("R1 pulse low", 64'(res_valid), 64'd0);

        // R6: earlier refusing entry wins over later granting one
        pid0 = 8'd0; sec_pids = 1'b0; as_data = 1'b0; as_instr = 1'b0;
        write_ent(0, 1'b1, 32'h2000_0000, 32'h3000_0000, 8'd0, 3'd1, 1'b0, 8'h0F);
        write_ent(1, 1'b1, 32'h2000_0000, 32'h4000_0000, 8'd0, 3'd1, 1'b0, 8'h77);
        lookup(32'h2000_0123, 2'd0, 1'b0, "R6 first refuses");
        chk("R6 fault from entry 0", 64'(res_code), 64'd2);
        write_ent(0, 1'b1, 32'h2000_0000, 32'h3000_0000, 8'd0, 3'd1, 1'b1, 8'h0F);
        lookup(32'h2000_0123, 2'd0, 1'b0, "R6 later grants");
        chk("R6 entry 1 hit", 64'(res_ra), 64'h0_4000_0123);

        // R9: bit 3 of the nibble grants nothing
        write_ent(2, 1'b1, 32'h5000_0000, 32'h6000_0000, 8'd0, 3'd0, 1'b0, 8'h08);
        lookup(32'h5000_0010, 2'd0, 1'b1, "R9 bit3 ignored");
        chk("R9 bit3 load refused", 64'(res_code), 64'd2);

        // R4: secondary tags ignored without the mode
        pid0 = 8'd1; pid1 = 8'd33; pid2 = 8'd44;
        write_ent(3, 1'b1, 32'h7000_0000, 32'h7100_0000, 8'd33, 3'd0, 1'b0, 8'hFF);
        sec_pids = 1'b0;
        lookup(32'h7000_0004, 2'd0, 1'b0, "R4 sec off");
        chk("R4 pid1 ignored", 64'(res_code), 64'd1);
        sec_pids = 1'b1;
        lookup(32'h7000_0004, 2'd0, 1'b0, "R4 sec on");
        chk("R4 pid1 used", 64'(res_code), 64'd0);

        // R2: same-cycle write and lookup sees the old entry
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 3'd3; wr_vld = 1'b0;
        lk_ea = 32'h7000_0004; lk_access = 2'd0; lk_user = 1'b0; lk_valid = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; lk_valid = 1'b0;
        m_vld[3] = 1'b0;
        chk("R2 old contents", 64'(res_code), 64'd0);
        lookup(32'h7000_0004, 2'd0, 1'b0, "R2 after write");
        chk("R2 new contents", 64'(res_code), 64'd1);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule